// File: doc/BRIEF.md
# Windowed Overlapping Register File

This block is the register file of a processor that passes procedure arguments in registers. The storage holds one small group of globals that every procedure sees, plus a ring of per-procedure windows. A 5-bit logical register number is translated through a current-window pointer into a physical entry. A call strobe moves the pointer one window deeper and a return strobe moves it back one window.

Each window has three segments: incoming, local and outgoing. The outgoing segment of one window is the same physical storage as the incoming segment of the next window. A caller therefore places arguments where the callee finds them, and the callee leaves results where the caller finds them, without copying any data. The number of windows is finite, so a call at the deepest window and a return at the outermost window are both refused and reported on flags.

The block has two combinational read ports and one write port that is committed on the clock edge.

Top module: `regwin_file`

## Requirements
- R1: Logical registers 1–7 are globals. They map to the same physical entries in every window, so a value written in one window reads back unchanged in any other window.
- R2: An accepted call raises `curWin` by one at the next clock edge. An accepted return lowers it by one at the next clock edge.
- R3: A call while `curWin` equals NWIN-1 (7 by default) leaves `curWin` unchanged. It drives `overflow` high for exactly the following cycle.
- R4: A return while `curWin` is 0 leaves `curWin` unchanged. It drives `underflow` high for exactly the following cycle.
- R5: Logical registers 24–31 (outgoing) of window w are the same physical entries as logical registers 8–15 (incoming) of window w+1, matched offset for offset. Arguments and results pass through them in both directions.
- R6: Logical registers 16–23 (locals) are private to each window. A write in one window is not visible in a neighbouring window.
- R7: Window numbering wraps: the outgoing segment of window NWIN-1 is the incoming segment of window 0.
- R8: Logical register 0 reads as zero on both ports. Writes to it have no effect.
- R9: A write takes effect at the rising clock edge. A read of the same register in the same cycle returns the old value.
- R10: When call and return are asserted together, both are ignored. `curWin` holds and neither flag rises.
- R11: A write issued in the same cycle as an accepted call uses the window mapping from before the call.
- R12: A synchronous reset sets `curWin` to 0 and clears `overflow` and `underflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 5 | Logical register number for read port A |
| rdDataA | output | 32 | Read port A data, combinational |
| rdAddrB | input | 5 | Logical register number for read port B |
| rdDataB | output | 32 | Read port B data, combinational |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Logical register number to write |
| wrData | input | 32 | Write data |
| callReq | input | 1 | Call strobe: move to the next window |
| retReq | input | 1 | Return strobe: move back to the previous window |
| curWin | output | 3 | Current window pointer |
| overflow | output | 1 | Pulses after a refused call |
| underflow | output | 1 | Pulses after a refused return |

## Verification
The main function is tried with several patterns:
- A caller writes outgoing registers, then the callee reads incoming registers. This separates true aliasing from a mapping that gives each window fresh storage.
- A callee writes incoming registers, then the caller reads outgoing registers after the return. This shows that the alias works in both directions.
- Locals are written with different values in two windows and read back after moving between them. This tells private storage apart from shared storage.
- A value is passed from the deepest window to window 0. This separates a wrapping mapping from a clamped one.

Further directed cases cover:
- A write in a call cycle, which tells old-mapping writes from new-mapping writes.
- Simultaneous strobes.
- Refused calls and refused returns.
- Register 0.
- Same-cycle read-after-write.
- Reset in the middle of a run.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Strobes from control to datapath: move the window pointer.
  typedef struct packed {
    logic advance;
    logic retreat;
  } winStep_t;

  // Logical segment selected by the top two bits of a register number.
  typedef enum logic [1:0] {
    SEG_GLOBAL = 2'd0,
    SEG_IN     = 2'd1,
    SEG_LOCAL  = 2'd2,
    SEG_OUT    = 2'd3
  } segKind_t;

endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int WINW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            callReq,
  input  logic            retReq,
  input  logic [WINW-1:0] curWin,
  output winStep_t        step,
  output logic            overflow,
  output logic            underflow
);

  localparam logic [WINW-1:0] LASTWIN = WINW'(NWIN - 1);

  logic onlyCall;
  logic onlyRet;
  logic atLast;
  logic atFirst;

  always_comb begin
    onlyCall     = callReq && !retReq;
    onlyRet      = retReq && !callReq;
    atLast       = (curWin == LASTWIN);
    atFirst      = (curWin == '0);
    step.advance = onlyCall && !atLast;
    step.retreat = onlyRet && !atFirst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= onlyCall && atLast;
      underflow <= onlyRet && atFirst;
    end
  end

endmodule

// File: rtl/regwin_data.sv
module regwin_data
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int SEGREGS = 8,
  localparam int NSEG    = 2 * NWIN,
  localparam int TOTAL   = SEGREGS + NSEG * SEGREGS,
  localparam int IDXW    = $clog2(TOTAL),
  localparam int WINW    = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  winStep_t        step,
  input  logic [4:0]      rdAddrA,
  output logic [DW-1:0]   rdDataA,
  input  logic [4:0]      rdAddrB,
  output logic [DW-1:0]   rdDataB,
  input  logic            wrEn,
  input  logic [4:0]      wrAddr,
  input  logic [DW-1:0]   wrData,
  output logic [WINW-1:0] curWin
);

  logic [DW-1:0] bank [TOTAL];

  // Translate a logical number into a physical index for window win.
  // Each window owns two segments (incoming, local). Its outgoing
  // segment is the incoming segment of the next window, modulo the ring.
  function automatic logic [IDXW-1:0] physIdx(input logic [4:0] lr,
                                              input logic [WINW-1:0] win);
    segKind_t kind;
    int       slot;
    int       idx;
    kind = segKind_t'(lr[4:3]);
    slot = 2 * int'(win);
    case (kind)
      SEG_IN:    slot = slot;
      SEG_LOCAL: slot = slot + 1;
      SEG_OUT:   slot = slot + 2;
      default:   slot = 0;
    endcase
    if (slot >= NSEG) slot = slot - NSEG;
    if (kind == SEG_GLOBAL) idx = int'(lr[2:0]);
    else                    idx = SEGREGS + slot * SEGREGS + int'(lr[2:0]);
    return IDXW'(idx);
  endfunction

  logic [IDXW-1:0] idxA;
  logic [IDXW-1:0] idxB;
  logic [IDXW-1:0] idxW;

  always_comb begin
    idxA = physIdx(rdAddrA, curWin);
    idxB = physIdx(rdAddrB, curWin);
    idxW = physIdx(wrAddr, curWin);
    rdDataA = (rdAddrA == 5'd0) ? '0 : bank[idxA];
    rdDataB = (rdAddrB == 5'd0) ? '0 : bank[idxB];
  end

  // Storage: old mapping applies to the write because curWin
  // changes on the same edge.
  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr != 5'd0)) bank[idxW] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)               curWin <= '0;
    else if (step.advance) curWin <= curWin + 1'b1;
    else if (step.retreat) curWin <= curWin - 1'b1;
  end

endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int WINW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      rdAddrA,
  output logic [DW-1:0]   rdDataA,
  input  logic [4:0]      rdAddrB,
  output logic [DW-1:0]   rdDataB,
  input  logic            wrEn,
  input  logic [4:0]      wrAddr,
  input  logic [DW-1:0]   wrData,
  input  logic            callReq,
  input  logic            retReq,
  output logic [WINW-1:0] curWin,
  output logic            overflow,
  output logic            underflow
);

  winStep_t step;

  regwin_ctrl #(.NWIN(NWIN)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .callReq   (callReq),
    .retReq    (retReq),
    .curWin    (curWin),
    .step      (step),
    .overflow  (overflow),
    .underflow (underflow)
  );

  regwin_data #(.NWIN(NWIN), .DW(DW)) uData (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .rdAddrA (rdAddrA),
    .rdDataA (rdDataA),
    .rdAddrB (rdAddrB),
    .rdDataB (rdDataB),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .curWin  (curWin)
  );

endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int WINW = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rst,
  input logic [4:0]      rdAddrA,
  input logic [DW-1:0]   rdDataA,
  input logic [4:0]      rdAddrB,
  input logic [DW-1:0]   rdDataB,
  input logic            callReq,
  input logic            retReq,
  input logic [WINW-1:0] curWin,
  input logic            overflow,
  input logic            underflow
);

  localparam logic [WINW-1:0] LASTWIN = WINW'(NWIN - 1);

  assert_call_advances_R2: assert property (@(posedge clk) disable iff (rst)
    (callReq && !retReq && curWin != LASTWIN) |=> (curWin == $past(curWin) + 1'b1));

  assert_ret_retreats_R2: assert property (@(posedge clk) disable iff (rst)
    (retReq && !callReq && curWin != '0) |=> (curWin == $past(curWin) - 1'b1));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (callReq && !retReq && curWin == LASTWIN) |=> (overflow && $stable(curWin)));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (retReq && !callReq && curWin == '0) |=> (underflow && $stable(curWin)));

  assert_zero_reads_R8: assert property (@(posedge clk) disable iff (rst)
    ((rdAddrA == 5'd0) |-> (rdDataA == '0)) and ((rdAddrB == 5'd0) |-> (rdDataB == '0)));

  assert_both_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (callReq && retReq) |=> ($stable(curWin) && !overflow && !underflow));

  assert_reset_state_R12: assert property (@(posedge clk)
    rst |=> (curWin == '0 && !overflow && !underflow));

endmodule

bind regwin_file regwin_file_chk #(.NWIN(NWIN), .DW(DW)) uChk (
  .clk       (clk),
  .rst       (rst),
  .rdAddrA   (rdAddrA),
  .rdDataA   (rdDataA),
  .rdAddrB   (rdAddrB),
  .rdDataB   (rdDataB),
  .callReq   (callReq),
  .retReq    (retReq),
  .curWin    (curWin),
  .overflow  (overflow),
  .underflow (underflow)
);

// File: tb/sim_regwin_file.sv
`timescale 1ns/1ps
module sim_regwin_file;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, callReq = 1'b0, retReq = 1'b0;
  logic [2:0]  curWin;
  logic        overflow, underflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  regwin_file u0 (
    .clk(clk), .rst(rst),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .callReq(callReq), .retReq(retReq),
    .curWin(curWin), .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, release 1 ns after the rising edge.
  task automatic tick(input logic c, input logic r, input logic we,
                      input logic [4:0] wa, input logic [31:0] wd);
    @(negedge clk);
    callReq = c; retReq = r; wrEn = we; wrAddr = wa; wrData = wd;
    @(posedge clk);
    #1;
    callReq = 1'b0; retReq = 1'b0; wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] ra, input logic [4:0] rb);
    rdAddrA = ra; rdAddrB = rb;
    #1;
  endtask

  // Vector: {op[1:0], reg[4:0], data[31:0], expWin[2:0]}
  // op 0 write, 1 read-check (both ports), 2 call, 3 return.
  localparam int NV = 14;
  localparam logic [41:0] VEC [NV] = '{
    {2'd0, 5'd1,  32'h0000_0011, 3'd0},  // global in window 0
    {2'd0, 5'd24, 32'h0000_00A0, 3'd0},  // argument out
    {2'd0, 5'd16, 32'h0000_0050, 3'd0},  // local of window 0
    {2'd2, 5'd0,  32'h0,         3'd1},  // call
    {2'd1, 5'd8,  32'h0000_00A0, 3'd1},  // R5 arg seen as incoming
    {2'd1, 5'd1,  32'h0000_0011, 3'd1},  // R1 global shared
    {2'd0, 5'd16, 32'h0000_0051, 3'd1},  // local of window 1
    {2'd0, 5'd8,  32'h0000_00B1, 3'd1},  // result in incoming
    {2'd3, 5'd0,  32'h0,         3'd0},  // return
    {2'd1, 5'd24, 32'h0000_00B1, 3'd0},  // R5 result seen by caller
    {2'd1, 5'd16, 32'h0000_0050, 3'd0},  // R6 local kept
    {2'd2, 5'd0,  32'h0,         3'd1},  // call
    {2'd1, 5'd16, 32'h0000_0051, 3'd1},  // R6 local kept
    {2'd3, 5'd0,  32'h0,         3'd0}   // return
  };

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(1'b0, 1'b0, 1'b0, 5'd0, 32'd0);
    tick(1'b0, 1'b0, 1'b0, 5'd0, 32'd0);
    rst = 1'b0;
    // R12 reset state
    chk("R12 curWin", 32'(curWin), 32'd0);
    chk("R12 flags", {30'd0, overflow, underflow}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [4:0]  rg;
      logic [31:0] dv;
      logic [2:0]  ew;
      {op, rg, dv, ew} = VEC[i];
      case (op)
        2'd0: tick(1'b0, 1'b0, 1'b1, rg, dv);
        2'd1: begin
          rd(rg, rg);
          chk("R1/R5/R6 vector port A", rdDataA, dv);
          chk("R1/R5/R6 vector port B", rdDataB, dv);
        end
        2'd2: tick(1'b1, 1'b0, 1'b0, 5'd0, 32'd0);
        default: tick(1'b0, 1'b1, 1'b0, 5'd0, 32'd0);
      endcase
      chk("R2 vector window", 32'(curWin), 32'(ew));
    end

    // R8: register 0
    tick(1'b0, 1'b0, 1'b1, 5'd0, 32'hDEAD_BEEF);
    rd(5'd0, 5'd0);
    chk("R8 port A", rdDataA, 32'd0);
    chk("R8 port B", rdDataB, 32'd0);

    // R9: same-cycle read returns old value
    tick(1'b0, 1'b0, 1'b1, 5'd3, 32'h0000_0333);
    @(negedge clk);
    rdAddrA = 5'd3; wrEn = 1'b1; wrAddr = 5'd3; wrData = 32'h0000_0444;
    #1;
    chk("R9 old value", rdDataA, 32'h0000_0333);
    @(posedge clk); #1; wrEn = 1'b0;
    chk("R9 new value", rdDataA, 32'h0000_0444);

    // R4: return at window 0
    tick(1'b0, 1'b1, 1'b0, 5'd0, 32'd0);
    chk("R4 underflow", 32'(underflow), 32'd1);
    chk("R4 window held", 32'(curWin), 32'd0);
    tick(1'b0, 1'b0, 1'b0, 5'd0, 32'd0);
    chk("R4 underflow pulse", 32'(underflow), 32'd0);

    // R10: both strobes at window 0
    tick(1'b1, 1'b1, 1'b0, 5'd0, 32'd0);
    chk("R10 window", 32'(curWin), 32'd0);
    chk("R10 flags", {30'd0, overflow, underflow}, 32'd0);

    // R11: write out register in the call cycle uses old mapping
    tick(1'b1, 1'b0, 1'b1, 5'd26, 32'h0000_0C0C);
    rd(5'd10, 5'd26);
    chk("R11 window", 32'(curWin), 32'd1);
    chk("R11 arrives as incoming", rdDataA, 32'h0000_0C0C);

    // R3: climb to the last window and call once more
    for (int k = 0; k < 6; k++) tick(1'b1, 1'b0, 1'b0, 5'd0, 32'd0);
    chk("R2 at deepest", 32'(curWin), 32'd7);
    tick(1'b1, 1'b0, 1'b0, 5'd0, 32'd0);
    chk("R3 overflow", 32'(overflow), 32'd1);
    chk("R3 window held", 32'(curWin), 32'd7);
    tick(1'b0, 1'b0, 1'b0, 5'd0, 32'd0);
    chk("R3 overflow pulse", 32'(overflow), 32'd0);

    // R7: outgoing of window 7 is incoming of window 0
    tick(1'b0, 1'b0, 1'b1, 5'd29, 32'h0000_0777);
    for (int k = 0; k < 7; k++) tick(1'b0, 1'b1, 1'b0, 5'd0, 32'd0);
    rd(5'd13, 5'd1);
    chk("R7 window", 32'(curWin), 32'd0);
    chk("R7 wrap alias", rdDataA, 32'h0000_0777);
    chk("R1 global after travel", rdDataB, 32'h0000_0011);

    // R12: reset mid-run
    tick(1'b1, 1'b0, 1'b0, 5'd0, 32'd0);
    tick(1'b1, 1'b0, 1'b0, 5'd0, 32'd0);
    @(negedge clk); rst = 1'b1; retReq = 1'b1;
    @(posedge clk); #1; rst = 1'b0; retReq = 1'b0;
    chk("R12 mid-run window", 32'(curWin), 32'd0);
    chk("R12 mid-run flags", {30'd0, overflow, underflow}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule